// File: doc/BRIEF.md
# Shared-Register PF/VF Mailbox Bank

This block holds one 32-bit mailbox word for each virtual function (VF). The physical function (PF) reaches any word through its own access port. The VF port is indexed by the identity of the requesting VF, so a VF only ever reads or writes its own word. The lower 16 bits carry traffic from the PF to that VF. The upper 16 bits carry traffic from the VF to the PF. Each half holds a doorbell bit, an origin flag, a 4-bit type field and message data. The data fields are stored without any interpretation.

Ringing the doorbell of a half raises an interrupt toward the receiver. The receiver acknowledges by writing that doorbell bit back to 0. Before a sender rings, it claims the word by writing a fixed in-use pattern into the other side's half. When the two sides claim the same word at once, the block records a per-VF collision flag and holds back doorbells until a clean claim goes through. Writes are half-granular through a two-bit lane enable.

Top module: `pfvf_mailbox_bank`

## Requirements
- R1: A synchronous active-low reset clears every mailbox word, every VF interrupt, the PF interrupt, the pending bitmap and all collision flags.
- R2: The PF port writes and reads the word selected by `pf_addr`. The VF port writes and reads only the word selected by `vf_sel`. Reads are combinational. A write lands on the next rising clock edge. Lane enable bit 0 selects bits 15:0 and lane enable bit 1 selects bits 31:16.
- R3: An accepted write that leaves bit 0 of word i at 1 asserts `vf_irq[i]` from the next cycle.
- R4: An accepted write that leaves bit 16 of word i at 1 sets `pf_pend[i]`. `pf_irq` is high whenever any bit of `pf_pend` is high.
- R5: A half write whose doorbell bit (bit 0 of the half) is 1 and whose origin flag (bit 1 of the half) is 0 is discarded. The half keeps its old value and no interrupt is raised.
- R6: Writing a half with its doorbell bit at 0 clears that doorbell, and the matching interrupt or pending bit drops from the next cycle.
- R7: A write of the in-use pattern `INUSE` (default 16'h6A5C) into one half, while the other half already holds `INUSE`, is discarded and sets `coll[i]`.
- R8: While `coll[i]` is set, any half write to word i with its doorbell bit at 1 is discarded. A successful `INUSE` claim write to word i clears `coll[i]`.
- R9: When both ports write the same word in one cycle, the PF write is applied, the VF write is discarded and `coll[i]` is set. Writes to different words in one cycle are both applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pf_wr | input | 1 | PF write strobe |
| pf_addr | input | VFW | PF word index |
| pf_be | input | 2 | PF half enables (bit0 low half, bit1 high half) |
| pf_wdata | input | 32 | PF write data |
| pf_rdata | output | 32 | Word at `pf_addr` |
| vf_wr | input | 1 | VF write strobe |
| vf_sel | input | VFW | Identity of the VF using the port |
| vf_be | input | 2 | VF half enables |
| vf_wdata | input | 32 | VF write data |
| vf_rdata | output | 32 | Word at `vf_sel` |
| vf_irq | output | NUM_VF | Per-VF interrupt (PF-to-VF doorbell) |
| pf_irq | output | 1 | PF interrupt, OR of pending VF doorbells |
| pf_pend | output | NUM_VF | VFs with a pending VF-to-PF doorbell |
| coll | output | NUM_VF | Per-VF collision flags |

## Verification
Several behaviours are checked by the assertions on every cycle. A same-word write from both ports must leave the collision flag set. A doorbell write without its origin flag must not raise a VF interrupt that was low. A doorbell write must not get through while the collision flag is set. Acknowledge writes from either side must drop the matching interrupt or pending bit.

Other behaviours can only be shown by the bench's scenarios. These are the full claim, collide, release and re-claim sequence, the stored message data and read-back on both ports, the PF-wins outcome of a same-word clash, and two ports writing different words in the same cycle without interfering.

// File: rtl/pfvf_mailbox_bank.sv
module pfvf_mailbox_bank #(
  parameter int NUM_VF = 4,
  parameter logic [15:0] INUSE = 16'h6A5C,
  localparam int VFW = (NUM_VF > 1) ? $clog2(NUM_VF) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pf_wr,
  input  logic [VFW-1:0]    pf_addr,
  input  logic [1:0]        pf_be,
  input  logic [31:0]       pf_wdata,
  output logic [31:0]       pf_rdata,
  input  logic              vf_wr,
  input  logic [VFW-1:0]    vf_sel,
  input  logic [1:0]        vf_be,
  input  logic [31:0]       vf_wdata,
  output logic [31:0]       vf_rdata,
  output logic [NUM_VF-1:0] vf_irq,
  output logic              pf_irq,
  output logic [NUM_VF-1:0] pf_pend,
  output logic [NUM_VF-1:0] coll
);

  logic [31:0]       mbox    [NUM_VF];
  logic [31:0]       mbox_nx [NUM_VF];
  logic [NUM_VF-1:0] coll_nx;

  // returns {collision, accept}
  function automatic logic [1:0] judge(input logic [15:0] d, input logic [15:0] other,
                                       input logic c);
    if (d == INUSE && other == INUSE) return 2'b10;
    if (d[0] && !d[1])                return 2'b00;
    if (d[0] && c)                    return 2'b00;
    return 2'b01;
  endfunction

  always_comb begin
    for (int i = 0; i < NUM_VF; i++) begin : g_next
      logic        pf_hit, vf_hit, wen;
      logic [1:0]  be, lo_r, hi_r;
      logic [31:0] d;
      logic        set_c, clr_c;
      pf_hit = pf_wr && (pf_addr == VFW'(i));
      vf_hit = vf_wr && (vf_sel == VFW'(i));
      wen    = pf_hit || vf_hit;
      be     = pf_hit ? pf_be : vf_be;
      d      = pf_hit ? pf_wdata : vf_wdata;
      lo_r   = judge(d[15:0], mbox[i][31:16], coll[i]);
      hi_r   = judge(d[31:16], mbox[i][15:0], coll[i]);
      mbox_nx[i] = mbox[i];
      if (wen && be[0] && lo_r[0]) mbox_nx[i][15:0]  = d[15:0];
      if (wen && be[1] && hi_r[0]) mbox_nx[i][31:16] = d[31:16];
      set_c = (pf_hit && vf_hit) || (wen && be[0] && lo_r[1]) || (wen && be[1] && hi_r[1]);
      clr_c = wen && ((be[0] && lo_r[0] && d[15:0] == INUSE) ||
                      (be[1] && hi_r[0] && d[31:16] == INUSE));
      coll_nx[i] = set_c ? 1'b1 : (clr_c ? 1'b0 : coll[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_VF; i++) mbox[i] <= '0;
      coll <= '0;
    end else begin
      for (int i = 0; i < NUM_VF; i++) mbox[i] <= mbox_nx[i];
      coll <= coll_nx;
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_VF; i++) begin
      vf_irq[i]  = mbox[i][0];
      pf_pend[i] = mbox[i][16];
    end
  end

  assign pf_irq   = |pf_pend;
  assign pf_rdata = mbox[pf_addr];
  assign vf_rdata = mbox[vf_sel];

endmodule

module pfvf_mailbox_bank_chk #(
  parameter int NUM_VF = 4,
  parameter logic [15:0] INUSE = 16'h6A5C,
  localparam int VFW = (NUM_VF > 1) ? $clog2(NUM_VF) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pf_wr,
  input logic [VFW-1:0]    pf_addr,
  input logic [1:0]        pf_be,
  input logic [31:0]       pf_wdata,
  input logic              vf_wr,
  input logic [VFW-1:0]    vf_sel,
  input logic [1:0]        vf_be,
  input logic [31:0]       vf_wdata,
  input logic [NUM_VF-1:0] vf_irq,
  input logic [NUM_VF-1:0] pf_pend,
  input logic [NUM_VF-1:0] coll
);

  // R9
  same_word_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_wr && vf_wr && pf_addr == vf_sel) |=> coll[$past(vf_sel)]);

  // R5
  no_origin_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_wr && pf_be[0] && pf_wdata[0] && !pf_wdata[1] && !vf_irq[pf_addr])
    |=> !vf_irq[$past(pf_addr)]);

  // R8
  coll_blocks_bell_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_wr && pf_be[0] && pf_wdata[0] && coll[pf_addr] && !vf_irq[pf_addr])
    |=> !vf_irq[$past(pf_addr)]);

  // R6
  pf_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_wr && pf_be[1] && !pf_wdata[16] && pf_wdata[31:16] != INUSE)
    |=> !pf_pend[$past(pf_addr)]);

  // R6
  vf_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vf_wr && vf_be[0] && !vf_wdata[0] && vf_wdata[15:0] != INUSE &&
     !(pf_wr && pf_addr == vf_sel))
    |=> !vf_irq[$past(vf_sel)]);

endmodule

bind pfvf_mailbox_bank pfvf_mailbox_bank_chk #(.NUM_VF(NUM_VF), .INUSE(INUSE)) u_chk (
  .clk(clk), .rst_n(rst_n), .pf_wr(pf_wr), .pf_addr(pf_addr), .pf_be(pf_be),
  .pf_wdata(pf_wdata), .vf_wr(vf_wr), .vf_sel(vf_sel), .vf_be(vf_be),
  .vf_wdata(vf_wdata), .vf_irq(vf_irq), .pf_pend(pf_pend), .coll(coll)
);

// File: tb/pfvf_mailbox_bank_bench.sv
module pfvf_mailbox_bank_bench;
  localparam int NV = 4;
  localparam logic [15:0] IU = 16'h6A5C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pf_wr = 1'b0, vf_wr = 1'b0;
  logic [1:0]  pf_addr = '0, vf_sel = '0, pf_be = '0, vf_be = '0;
  logic [31:0] pf_wdata = '0, vf_wdata = '0, pf_rdata, vf_rdata;
  logic [NV-1:0] vf_irq, pf_pend, coll;
  logic        pf_irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pfvf_mailbox_bank #(.NUM_VF(NV), .INUSE(IU)) u_pfvf_mailbox_bank (
    .clk(clk), .rst_n(rst_n), .pf_wr(pf_wr), .pf_addr(pf_addr), .pf_be(pf_be),
    .pf_wdata(pf_wdata), .pf_rdata(pf_rdata), .vf_wr(vf_wr), .vf_sel(vf_sel),
    .vf_be(vf_be), .vf_wdata(vf_wdata), .vf_rdata(vf_rdata), .vf_irq(vf_irq),
    .pf_irq(pf_irq), .pf_pend(pf_pend), .coll(coll));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic pw, logic [1:0] pa, logic [1:0] pb, logic [31:0] pd,
                       logic vw, logic [1:0] vs, logic [1:0] vb, logic [31:0] vd);
    @(negedge clk);
    pf_wr = pw; pf_addr = pa; pf_be = pb; pf_wdata = pd;
    vf_wr = vw; vf_sel = vs; vf_be = vb; vf_wdata = vd;
    @(negedge clk);
    pf_wr = 0; vf_wr = 0;
  endtask

  task automatic pfw(logic [1:0] a, logic [1:0] b, logic [31:0] d);
    drive(1, a, b, d, 0, 0, 0, 0);
  endtask

  task automatic vfw(logic [1:0] s, logic [1:0] b, logic [31:0] d);
    drive(0, 0, 0, 0, 1, s, b, d);
  endtask

  task automatic t_reset();
    chk("R1 vf_irq", 32'(vf_irq), 0);
    chk("R1 pf_irq", 32'(pf_irq), 0);
    chk("R1 coll", 32'(coll), 0);
    pf_addr = 3; vf_sel = 3; #1;
    chk("R1 pf_rdata", pf_rdata, 0);
    chk("R1 vf_rdata", vf_rdata, 0);
  endtask

  task automatic t_pf_to_vf();
    pfw(2, 2'b01, 32'hFFFF_0037);
    chk("R3 vf_irq", 32'(vf_irq), 32'h4);
    chk("R2 upper half untouched", pf_rdata, 32'h0000_0037);
    vf_sel = 2; #1;
    chk("R2 vf read own", vf_rdata, 32'h0000_0037);
    vf_sel = 1; #1;
    chk("R2 vf other index", vf_rdata, 0);
    vfw(2, 2'b01, 32'h0000_0036);
    chk("R6 vf ack", 32'(vf_irq), 0);
  endtask

  task automatic t_vf_to_pf();
    vfw(1, 2'b10, 32'h0013_0000);
    chk("R4 pf_pend", 32'(pf_pend), 32'h2);
    chk("R4 pf_irq", 32'(pf_irq), 1);
    pf_addr = 1; #1;
    chk("R2 pf read", pf_rdata, 32'h0013_0000);
    pfw(1, 2'b10, 32'h0012_0000);
    chk("R6 pf ack", 32'(pf_irq), 0);
  endtask

  task automatic t_origin();
    pfw(0, 2'b01, 32'h0000_00F1);
    chk("R5 no irq", 32'(vf_irq), 0);
    pf_addr = 0; #1;
    chk("R5 half kept", pf_rdata, 0);
    vfw(0, 2'b10, 32'h0001_0000);
    chk("R5 vf side no pend", 32'(pf_pend), 0);
  endtask

  task automatic t_claim();
    vfw(3, 2'b01, {16'h0, IU});
    chk("R7 vf claim ok", 32'(coll), 0);
    pfw(3, 2'b10, {IU, 16'h0});
    chk("R7 coll set", 32'(coll), 32'h8);
    pf_addr = 3; #1;
    chk("R7 claim discarded", pf_rdata, {16'h0, IU});
    pfw(3, 2'b01, 32'h0000_0007);
    chk("R8 bell blocked", 32'(vf_irq), 0);
    vfw(3, 2'b01, 32'h0);
    pfw(3, 2'b10, {IU, 16'h0});
    chk("R8 reclaim clears", 32'(coll), 0);
    pfw(3, 2'b01, 32'h0000_0007);
    chk("R8 bell after reclaim", 32'(vf_irq), 32'h8);
  endtask

  task automatic t_clash();
    drive(1, 0, 2'b01, 32'h0000_0007, 1, 0, 2'b10, 32'h0003_0000);
    chk("R9 coll on clash", 32'(coll[0]), 1);
    pf_addr = 0; #1;
    chk("R9 pf wins", pf_rdata, 32'h0000_0007);
    chk("R9 vf dropped", 32'(pf_pend), 0);
    drive(1, 1, 2'b01, 32'h0000_0003, 1, 2, 2'b10, 32'h0003_0000);
    chk("R9 split pf", 32'(vf_irq[1]), 1);
    chk("R9 split vf", 32'(pf_pend), 32'h4);
    chk("R9 no new coll", 32'(coll), 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_pf_to_vf();
    t_vf_to_pf();
    t_origin();
    t_claim();
    t_clash();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    chk("R1 reset again", {coll, vf_irq, pf_pend}, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule